// File: doc/BRIEF.md
# Scaled Index Address Adder

This unit computes array-style addresses for a 64-bit core. A first operand, which is usually an index, is optionally narrowed to its low 32 bits. It is then scaled by a left shift and added to a second operand, which is usually a base address. One more form shifts the zero-extended low word left by a 6-bit amount from an immediate field and adds nothing.

A 3-bit operation code selects the form. All arithmetic wraps modulo 2^64. Reading the index operand as signed or unsigned makes no difference to the result bits.

The arithmetic is a single combinational path. A parameter places an optional output register after it. That register captures the result on cycles where the input valid bit is high and holds it on other cycles, and it carries the valid bit forward. In the default build the register is present, so the result appears one clock after the operands.

Top module: `scaled_index_adder`

## Requirements
- R1: Code 0 gives `{32'b0, a[31:0]} + b`, with the upper half of `a` ignored.
- R2: Codes 1, 2 and 3 give `(a << k) + b` for k = 1, 2 and 3, keeping only the low 64 bits.
- R3: Codes 4, 5 and 6 clear `a[63:32]` first, then give `(a << k) + b` for k = 1, 2 and 3 respectively.
- R4: Code 7 gives `{32'b0, a[31:0]} << shamt`. `b` is ignored, and bits moved above bit 63 are lost.
- R5: For codes 0 to 6 the `shamt` input has no effect on the result.
- R6: Sums wrap modulo 2^64, so a carry out of bit 63 is dropped.
- R7: With the output register present, `result` and `out_valid` reflect the operands presented one clock earlier with `in_valid` high.
- R8: On a cycle where `in_valid` is low, `result` keeps its previous value and `out_valid` goes low at the next clock.
- R9: While `rst_n` is low, `out_valid` is 0 and `result` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands and code are valid this cycle |
| op_sel | input | 3 | Operation code, 0 to 7 |
| opnd_a | input | 64 | Index operand |
| opnd_b | input | 64 | Base operand |
| shamt | input | 6 | Shift amount for code 7 |
| out_valid | output | 1 | Result holds a fresh value |
| result | output | 64 | Computed address |

## Verification
The bench places ones in the upper half of `a` for every zero-extending code. A design that forgot the mask would then leak those bits into the sum. It drives all-ones operands so that a carry runs out of bit 63, which catches an adder built wider than 64 bits or one that saturates. The shift immediate is tested at 0, 31, 32 and 63, and index words of 0x8000_0000 are used; these catch a shifter that sign-extends the low word or truncates the amount. It also drives a nonzero `shamt` under the adding codes, and holds `in_valid` low while changing the operands, which exposes a shift decode that leaks into those codes and an output register with no enable.

// File: rtl/sia_pkg.sv
package sia_pkg;

  typedef enum logic [2:0] {
    OP_ZADD    = 3'd0,
    OP_S1ADD   = 3'd1,
    OP_S2ADD   = 3'd2,
    OP_S3ADD   = 3'd3,
    OP_S1ZADD  = 3'd4,
    OP_S2ZADD  = 3'd5,
    OP_S3ZADD  = 3'd6,
    OP_ZSHL    = 3'd7
  } sia_op_e;

  typedef struct packed {
    logic       zext;
    logic       use_imm;
    logic [1:0] scale;
  } sia_ctl_t;

endpackage

// File: rtl/sia_decode.sv
module sia_decode
  import sia_pkg::*;
(
  input  logic [2:0] op_sel,
  output sia_ctl_t   ctl
);

  always_comb begin
    ctl = '0;
    case (sia_op_e'(op_sel))
      OP_ZADD:   begin ctl.zext = 1'b1; ctl.scale = 2'd0; end
      OP_S1ADD:  begin ctl.zext = 1'b0; ctl.scale = 2'd1; end
      OP_S2ADD:  begin ctl.zext = 1'b0; ctl.scale = 2'd2; end
      OP_S3ADD:  begin ctl.zext = 1'b0; ctl.scale = 2'd3; end
      OP_S1ZADD: begin ctl.zext = 1'b1; ctl.scale = 2'd1; end
      OP_S2ZADD: begin ctl.zext = 1'b1; ctl.scale = 2'd2; end
      OP_S3ZADD: begin ctl.zext = 1'b1; ctl.scale = 2'd3; end
      OP_ZSHL:   begin ctl.zext = 1'b1; ctl.use_imm = 1'b1; end
      default:   ctl = '0;
    endcase
  end

endmodule

// File: rtl/sia_shift_add.sv
module sia_shift_add
  import sia_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int WORD = 32,
  localparam int SHW = $clog2(XLEN)
) (
  input  sia_ctl_t          ctl,
  input  logic [XLEN-1:0]   opnd_a,
  input  logic [XLEN-1:0]   opnd_b,
  input  logic [SHW-1:0]    shamt,
  output logic [XLEN-1:0]   sum
);

  logic [XLEN-1:0] base;
  logic [XLEN-1:0] addend;
  logic [SHW-1:0]  amt;
  logic [XLEN-1:0] shifted;

  always_comb begin
    if (ctl.zext) base = {{(XLEN-WORD){1'b0}}, opnd_a[WORD-1:0]};
    else          base = opnd_a;
  end

  always_comb begin
    if (ctl.use_imm) begin
      amt    = shamt;
      addend = '0;
    end else begin
      amt    = SHW'(ctl.scale);
      addend = opnd_b;
    end
  end

  assign shifted = base << amt;
  assign sum     = shifted + addend;

endmodule

// File: rtl/sia_out_stage.sv
module sia_out_stage #(
  parameter int XLEN    = 64,
  parameter bit REG_OUT = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [XLEN-1:0] d,
  output logic            out_valid,
  output logic [XLEN-1:0] q
);

  generate
    if (REG_OUT) begin : g_reg
      logic [XLEN-1:0] data_d, data_q;
      logic            vld_d, vld_q;

      always_comb begin
        vld_d  = in_valid;
        data_d = data_q;
        if (in_valid) data_d = d;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          vld_q  <= 1'b0;
          data_q <= '0;
        end else begin
          vld_q  <= vld_d;
          data_q <= data_d;
        end
      end

      assign out_valid = vld_q;
      assign q         = data_q;

      a_r8_valid_drop: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
      a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(q));
      a_r7_capture: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_valid && q == $past(d)));
    end else begin : g_comb
      assign out_valid = in_valid;
      assign q         = d;
    end
  endgenerate

endmodule

// File: rtl/scaled_index_adder.sv
module scaled_index_adder
  import sia_pkg::*;
#(
  parameter int XLEN    = 64,
  parameter int WORD    = 32,
  parameter bit REG_OUT = 1'b1,
  localparam int SHW    = $clog2(XLEN)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [2:0]      op_sel,
  input  logic [XLEN-1:0] opnd_a,
  input  logic [XLEN-1:0] opnd_b,
  input  logic [SHW-1:0]  shamt,
  output logic            out_valid,
  output logic [XLEN-1:0] result
);

  sia_ctl_t        ctl;
  logic [XLEN-1:0] sum;

  sia_decode u_dec (
    .op_sel (op_sel),
    .ctl    (ctl)
  );

  sia_shift_add #(.XLEN(XLEN), .WORD(WORD)) u_sa (
    .ctl    (ctl),
    .opnd_a (opnd_a),
    .opnd_b (opnd_b),
    .shamt  (shamt),
    .sum    (sum)
  );

  sia_out_stage #(.XLEN(XLEN), .REG_OUT(REG_OUT)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .d         (sum),
    .out_valid (out_valid),
    .q         (result)
  );

  // R1: zero-extended add with a zero base never reaches the upper half
  a_r1_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == 3'd0 && opnd_b == '0) |-> (sum[XLEN-1:WORD] == '0));
  // R2: a scaled add with a zero base leaves bit 0 clear
  a_r2_low_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel inside {3'd1, 3'd2, 3'd3, 3'd4, 3'd5, 3'd6} && opnd_b == '0) |-> (sum[0] == 1'b0));
  // R4: immediate shift by zero returns the zero-extended low word
  a_r4_zero_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == 3'd7 && shamt == '0) |-> (sum == {{(XLEN-WORD){1'b0}}, opnd_a[WORD-1:0]}));
  // R3: triple-scaled zero-extended add with zero base stays below bit WORD+3
  a_r3_width: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == 3'd6 && opnd_b == '0) |-> (sum[XLEN-1:WORD+3] == '0));

endmodule

// File: tb/sim_scaled_index_adder.sv
module sim_scaled_index_adder;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [2:0]  op_sel;
  logic [63:0] opnd_a, opnd_b;
  logic [5:0]  shamt;
  logic        out_valid;
  logic [63:0] result;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  scaled_index_adder u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .shamt(shamt),
    .out_valid(out_valid), .result(result)
  );

  function automatic logic [63:0] ref_model(input logic [2:0] op, input logic [63:0] a,
                                            input logic [63:0] b, input logic [5:0] s);
    logic [63:0] lo;
    lo = {32'h0, a[31:0]};
    case (op)
      3'd0: return lo + b;
      3'd1: return a * 64'd2 + b;
      3'd2: return a * 64'd4 + b;
      3'd3: return a * 64'd8 + b;
      3'd4: return lo * 64'd2 + b;
      3'd5: return lo * 64'd4 + b;
      3'd6: return lo * 64'd8 + b;
      default: return lo << s;
    endcase
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input string req, input logic [2:0] op, input logic [63:0] a,
                       input logic [63:0] b, input logic [5:0] s);
    in_valid = 1'b1; op_sel = op; opnd_a = a; opnd_b = b; shamt = s;
    @(posedge clk);
    @(negedge clk);
    check(req, result, ref_model(op, a, b, s));
    check({req, " R7 valid"}, {63'h0, out_valid}, 64'h1);
  endtask

  task automatic t_reset();
    check("R9 valid", {63'h0, out_valid}, 64'h0);
    check("R9 result", result, 64'h0);
  endtask

  task automatic t_zadd();
    apply("R1", 3'd0, 64'hFFFF_FFFF_1234_5678, 64'h1000, 6'd0);
    apply("R1", 3'd0, 64'hDEAD_BEEF_8000_0000, 64'h0, 6'd0);
  endtask

  task automatic t_scaled();
    for (int k = 1; k <= 3; k++) begin
      apply("R2", 3'(k), 64'h8000_0000_0000_0001, 64'h40, 6'd0);
      apply("R2", 3'(k), 64'h0000_0000_8000_0000, 64'hFFFF_0000_0000_0000, 6'd0);
    end
  endtask

  task automatic t_scaled_zext();
    for (int k = 4; k <= 6; k++) begin
      apply("R3", 3'(k), 64'hFFFF_FFFF_8000_0000, 64'h7, 6'd0);
      apply("R3", 3'(k), 64'hABCD_0000_FFFF_FFFF, 64'h0, 6'd0);
    end
  endtask

  task automatic t_zshl();
    apply("R4", 3'd7, 64'hFFFF_FFFF_8000_0001, 64'h55, 6'd0);
    apply("R4", 3'd7, 64'hFFFF_FFFF_8000_0001, 64'h55, 6'd31);
    apply("R4", 3'd7, 64'hFFFF_FFFF_8000_0001, 64'hAA, 6'd32);
    apply("R4", 3'd7, 64'h0000_0000_FFFF_FFFF, 64'h0, 6'd63);
  endtask

  task automatic t_shamt_ignored();
    for (int k = 0; k <= 6; k++)
      apply("R5", 3'(k), 64'h0000_0001_0000_0003, 64'h10, 6'd17);
  endtask

  task automatic t_wrap();
    apply("R6", 3'd3, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 6'd0);
    apply("R6", 3'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 6'd0);
    check("R6 explicit", ref_model(3'd1, 64'h8000_0000_0000_0000, 64'h1, 6'd0), 64'h1);
  endtask

  task automatic t_hold();
    logic [63:0] prev;
    apply("R8 setup", 3'd2, 64'h1111, 64'h2222, 6'd0);
    prev = result;
    in_valid = 1'b0; op_sel = 3'd1; opnd_a = 64'hFFFF; opnd_b = 64'h1; shamt = 6'd5;
    @(posedge clk);
    @(negedge clk);
    check("R8 hold", result, prev);
    check("R8 valid low", {63'h0, out_valid}, 64'h0);
  endtask

  task automatic t_random();
    for (int i = 0; i < 200; i++)
      apply("R7 random", 3'($urandom), {$urandom, $urandom}, {$urandom, $urandom}, 6'($urandom));
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; op_sel = 3'd0; opnd_a = '0; opnd_b = '0; shamt = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_zadd();
    t_scaled();
    t_scaled_zext();
    t_zshl();
    t_shamt_ignored();
    t_wrap();
    t_hold();
    t_random();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule